// File: doc/BRIEF.md
# Block Transmit Sequencer for a CAN Message-Buffer Set

This block walks the lower group of a CAN controller's message buffers and raises their transmit requests one at a time, in ascending buffer number. Software sets a trigger bit to start a run. The engine requests the current buffer and waits until the protocol core reports that frame as sent. It then waits a programmable number of bit times and requests the next buffer. After the last buffer of the group completes, the engine stops by itself.

The upper buffers are ordinary buffers. Software sets and clears their requests directly, and the engine never touches them. A self-clearing rewind bit moves the engine back to the first buffer, but only while the trigger is low. To abort a run, software first drops the trigger and then clears the pending buffer's request. That clear is refused while the core reports the buffer's frame on the bus. If the trigger is set again after an abort and no rewind was made, the run resumes at the buffer that was pending.

Top module: `can_blk_tx_seq`

## Requirements
- R1: After reset, every request bit, the trigger, the rewind-pending flag, the error flag, the completion pulse and the in-flight flag are 0, and the pointer is 0.
- R2: When the trigger is set and the block-transmit mode is on, the buffer at the pointer gets its request one cycle later. Only one request bit in buffers 0..7 is high at a time, and the buffers follow ascending order.
- R3: After the pending buffer's transmit-complete pulse, the next request rises once the gap value has been counted down to zero. The counter decrements only in cycles where `bit_tick` is high. With the tick held high and a gap of N, the request is visible N+1 cycles after the completion edge.
- R4: With a gap of 0, the next request is visible one cycle after the completion edge.
- R5: When buffer 7 completes, the engine clears the trigger and returns the pointer to 0. In that same cycle it raises `seq_done` for exactly one cycle.
- R6: A rewind write while the trigger is 0 raises `rewind_pend` for exactly one cycle. After that cycle the pointer reads 0 and the error flag is cleared.
- R7: A rewind write while the trigger is 1 is ignored: `rewind_pend` stays 0 and `rewind_err` becomes 1.
- R8: A write of 1 to the trigger while `init_mode` is high is ignored, and no request follows it.
- R9: While `blk_mode` is high, software set writes to buffers 0..7 are ignored. While it is low, they take effect.
- R10: Request bits 8..15 change only through software set or clear writes and through their own complete pulses. The engine never affects them.
- R11: When software clears the pending request after dropping the trigger, the bit drops one cycle later and `blk_in_flight` drops one cycle after that, with the pointer unchanged. If `on_bus` is high for that buffer, the clear is refused and the bit stays high until the buffer's complete pulse.
- R12: Setting the trigger again after an abort, with no rewind in between, requests the buffer that was pending at the abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_tick | input | 1 | One-cycle enable per CAN bit time; drives the gap counter |
| init_mode | input | 1 | Controller is in initialization mode |
| blk_mode | input | 1 | Normal operation with block transmission is active |
| trig_wr | input | 1 | Write strobe for the trigger bit |
| trig_wdata | input | 1 | Value written to the trigger bit |
| rewind_wr | input | 1 | Write of 1 to the rewind bit |
| gap_wr | input | 1 | Write strobe for the gap register |
| gap_wdata | input | 8 | Gap in bit times between a completion and the next request |
| req_set | input | 16 | Software request-set writes, one bit per buffer |
| req_clr | input | 16 | Software request-clear (abort) writes, one bit per buffer |
| on_bus | input | 16 | The core is sending this buffer's frame on the bus |
| tx_done | input | 16 | One-cycle transmit-complete pulse per buffer |
| tx_req | output | 16 | Transmit request bits to the protocol core |
| trig | output | 1 | Trigger bit state |
| rewind_pend | output | 1 | Rewind in progress (self-clearing) |
| rewind_err | output | 1 | A rewind was requested while the trigger was set |
| seq_ptr | output | 3 | Buffer the engine requests next or is waiting on |
| seq_done | output | 1 | One-cycle pulse when the last block buffer completes |
| blk_in_flight | output | 1 | The engine's current request is outstanding |

## Verification
A wrong pointer or state register shows at `tx_req` within one cycle. The bit after a completion, or after a trigger write, would be the wrong one, or two lower bits would be high together. A gap counter that is off by one moves the rising edge of the next request by a cycle, so the bench samples that edge at an exact cycle and not inside a window. A lost abort or a missed rewind appears as `blk_in_flight`, `seq_ptr` or the bit that is requested after re-triggering. Errors in the pass-through bank appear directly on bits 8..15 one cycle after the write.

// File: rtl/can_blk_pkg.sv
package can_blk_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_GAP  = 2'd1,
    SEQ_WAIT = 2'd2
  } seq_state_e;

endpackage

// File: rtl/blk_gap_timer.sv
module blk_gap_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (load) begin
      cnt_d = load_val;
    end else if (tick && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/blk_req_bank.sv
module blk_req_bank #(
  parameter int NBUF = 16,
  parameter int NBLK = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            blk_mode,
  input  logic [NBUF-1:0] sw_set,
  input  logic [NBUF-1:0] sw_clr,
  input  logic [NBUF-1:0] on_bus,
  input  logic [NBUF-1:0] done,
  input  logic [NBLK-1:0] eng_set,
  output logic [NBUF-1:0] req
);

  logic [NBUF-1:0] req_q;
  logic [NBUF-1:0] req_d;

  for (genvar i = 0; i < NBUF; i++) begin : g_bit
    logic set_eff;
    logic clr_eff;

    if (i < NBLK) begin : g_blk
      // reserved group: engine sets; software sets only outside block mode
      assign set_eff = eng_set[i] | (sw_set[i] & ~blk_mode);
    end else begin : g_plain
      assign set_eff = sw_set[i];
    end

    // an abort clear is refused while the frame is on the bus
    assign clr_eff = sw_clr[i] & ~on_bus[i];

    always_comb begin
      req_d[i] = ((req_q[i] & ~clr_eff) | set_eff) & ~done[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q[i] <= 1'b0;
      end else begin
        req_q[i] <= req_d[i];
      end
    end
  end

  assign req = req_q;

endmodule

// File: rtl/blk_seq_ctrl.sv
module blk_seq_ctrl
  import can_blk_pkg::*;
#(
  parameter int NBLK = 8,
  parameter int GAPW = 8,
  localparam int PTRW = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            blk_mode,
  input  logic            init_mode,
  input  logic            trig_wr,
  input  logic            trig_wdata,
  input  logic            rewind_wr,
  input  logic            gap_wr,
  input  logic [GAPW-1:0] gap_wdata,
  input  logic [NBLK-1:0] blk_req,
  input  logic [NBLK-1:0] blk_done,
  input  logic            gap_zero,
  output logic            tmr_load,
  output logic            tmr_clr,
  output logic [GAPW-1:0] gap_val,
  output logic [NBLK-1:0] eng_set,
  output logic            trig,
  output logic            rewind_pend,
  output logic            rewind_err,
  output logic [PTRW-1:0] seq_ptr,
  output logic            seq_done,
  output logic            in_flight
);

  localparam logic [PTRW-1:0] LAST = PTRW'(NBLK - 1);

  seq_state_e      st_q, st_d;
  logic [PTRW-1:0] ptr_q, ptr_d;
  logic            trig_q, trig_d;
  logic            rew_q, rew_d;
  logic            err_q, err_d;
  logic            done_q, done_d;
  logic [GAPW-1:0] gap_q, gap_d;
  logic            cur_req;
  logic            cur_done;

  assign cur_req  = blk_req[ptr_q];
  assign cur_done = blk_done[ptr_q];

  always_comb begin
    st_d     = st_q;
    ptr_d    = ptr_q;
    trig_d   = trig_q;
    rew_d    = rew_q;
    err_d    = err_q;
    done_d   = 1'b0;
    gap_d    = gap_q;
    eng_set  = '0;
    tmr_load = 1'b0;
    tmr_clr  = 1'b0;

    if (gap_wr) begin
      gap_d = gap_wdata;
    end

    // trigger writes: clearing always allowed, setting gated by mode
    if (trig_wr) begin
      if (!trig_wdata) begin
        trig_d = 1'b0;
      end else if (!init_mode && blk_mode && !rew_q) begin
        trig_d = 1'b1;
      end
    end

    // rewind request: honoured only with trigger low
    if (rewind_wr && !rew_q) begin
      if (trig_q) begin
        err_d = 1'b1;
      end else begin
        rew_d = 1'b1;
      end
    end

    if (rew_q) begin
      rew_d   = 1'b0;
      ptr_d   = '0;
      err_d   = 1'b0;
      st_d    = SEQ_IDLE;
      tmr_clr = 1'b1;
    end else begin
      unique case (st_q)
        SEQ_IDLE: begin
          if (trig_q && blk_mode) begin
            eng_set[ptr_q] = 1'b1;
            st_d           = SEQ_WAIT;
          end
        end
        SEQ_GAP: begin
          if (!trig_q || !blk_mode) begin
            st_d = SEQ_IDLE;
          end else if (gap_zero) begin
            eng_set[ptr_q] = 1'b1;
            st_d           = SEQ_WAIT;
          end
        end
        SEQ_WAIT: begin
          if (cur_done) begin
            if (ptr_q == LAST) begin
              ptr_d  = '0;
              trig_d = 1'b0;
              done_d = 1'b1;
              st_d   = SEQ_IDLE;
            end else begin
              ptr_d = ptr_q + 1'b1;
              if (trig_q) begin
                tmr_load = 1'b1;
                st_d     = SEQ_GAP;
              end else begin
                st_d = SEQ_IDLE;
              end
            end
          end else if (!cur_req) begin
            // request withdrawn by a successful abort: keep pointer
            st_d = SEQ_IDLE;
          end
        end
        default: st_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      ptr_q  <= '0;
      trig_q <= 1'b0;
      rew_q  <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      trig_q <= trig_d;
      rew_q  <= rew_d;
      err_q  <= err_d;
      done_q <= done_d;
      gap_q  <= gap_d;
    end
  end

  assign gap_val     = gap_q;
  assign trig        = trig_q;
  assign rewind_pend = rew_q;
  assign rewind_err  = err_q;
  assign seq_ptr     = ptr_q;
  assign seq_done    = done_q;
  assign in_flight   = (st_q == SEQ_WAIT);

endmodule

// File: rtl/can_blk_tx_seq.sv
module can_blk_tx_seq #(
  parameter int NBUF = 16,
  parameter int NBLK = 8,
  parameter int GAPW = 8,
  localparam int PTRW = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_tick,
  input  logic            init_mode,
  input  logic            blk_mode,
  input  logic            trig_wr,
  input  logic            trig_wdata,
  input  logic            rewind_wr,
  input  logic            gap_wr,
  input  logic [GAPW-1:0] gap_wdata,
  input  logic [NBUF-1:0] req_set,
  input  logic [NBUF-1:0] req_clr,
  input  logic [NBUF-1:0] on_bus,
  input  logic [NBUF-1:0] tx_done,
  output logic [NBUF-1:0] tx_req,
  output logic            trig,
  output logic            rewind_pend,
  output logic            rewind_err,
  output logic [PTRW-1:0] seq_ptr,
  output logic            seq_done,
  output logic            blk_in_flight
);

  logic [1:0]      rst_sync_q;
  logic            rst_core_n;
  logic            tmr_load;
  logic            tmr_clr;
  logic            gap_zero;
  logic [GAPW-1:0] gap_val;
  logic [NBLK-1:0] eng_set;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  blk_seq_ctrl #(
    .NBLK (NBLK),
    .GAPW (GAPW)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .blk_mode    (blk_mode),
    .init_mode   (init_mode),
    .trig_wr     (trig_wr),
    .trig_wdata  (trig_wdata),
    .rewind_wr   (rewind_wr),
    .gap_wr      (gap_wr),
    .gap_wdata   (gap_wdata),
    .blk_req     (tx_req[NBLK-1:0]),
    .blk_done    (tx_done[NBLK-1:0]),
    .gap_zero    (gap_zero),
    .tmr_load    (tmr_load),
    .tmr_clr     (tmr_clr),
    .gap_val     (gap_val),
    .eng_set     (eng_set),
    .trig        (trig),
    .rewind_pend (rewind_pend),
    .rewind_err  (rewind_err),
    .seq_ptr     (seq_ptr),
    .seq_done    (seq_done),
    .in_flight   (blk_in_flight)
  );

  blk_gap_timer #(
    .W (GAPW)
  ) u_gap (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .clr      (tmr_clr),
    .load     (tmr_load),
    .load_val (gap_val),
    .tick     (bit_tick),
    .zero     (gap_zero)
  );

  blk_req_bank #(
    .NBUF (NBUF),
    .NBLK (NBLK)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .blk_mode (blk_mode),
    .sw_set   (req_set),
    .sw_clr   (req_clr),
    .on_bus   (on_bus),
    .done     (tx_done),
    .eng_set  (eng_set),
    .req      (tx_req)
  );

endmodule

// File: rtl/can_blk_tx_seq_chk.sv
module can_blk_tx_seq_chk #(
  parameter int NBUF = 16,
  parameter int NBLK = 8,
  localparam int PTRW = $clog2(NBLK)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 trig_wr,
  input logic                 trig_wdata,
  input logic                 init_mode,
  input logic                 rewind_wr,
  input logic [NBUF-NBLK-1:0] hi_set,
  input logic [NBUF-NBLK-1:0] hi_clr,
  input logic [NBUF-NBLK-1:0] hi_done,
  input logic [NBUF-1:0]      tx_req,
  input logic                 trig,
  input logic                 rewind_pend,
  input logic                 rewind_err,
  input logic [PTRW-1:0]      seq_ptr,
  input logic                 seq_done,
  input logic                 blk_in_flight
);

  logic [NBLK-1:0] lo_req;
  assign lo_req = tx_req[NBLK-1:0];

  assert_start_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_in_flight) |-> lo_req[seq_ptr]);

  assert_seq_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> (!trig && (seq_ptr == '0)));

  assert_rewind_selfclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rewind_pend |=> (!rewind_pend && (seq_ptr == '0)));

  assert_rewind_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rewind_wr && trig && !rewind_pend) |=> (rewind_err && !rewind_pend));

  assert_trig_init_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_wr && trig_wdata && init_mode && !trig) |=> !trig);

  assert_hi_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_req[NBUF-1:NBLK]) |->
      ($past(|hi_set) || $past(|hi_clr) || $past(|hi_done)));

endmodule

bind can_blk_tx_seq can_blk_tx_seq_chk #(
  .NBUF (NBUF),
  .NBLK (NBLK)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .trig_wr       (trig_wr),
  .trig_wdata    (trig_wdata),
  .init_mode     (init_mode),
  .rewind_wr     (rewind_wr),
  .hi_set        (req_set[NBUF-1:NBLK]),
  .hi_clr        (req_clr[NBUF-1:NBLK]),
  .hi_done       (tx_done[NBUF-1:NBLK]),
  .tx_req        (tx_req),
  .trig          (trig),
  .rewind_pend   (rewind_pend),
  .rewind_err    (rewind_err),
  .seq_ptr       (seq_ptr),
  .seq_done      (seq_done),
  .blk_in_flight (blk_in_flight)
);

// File: tb/can_blk_tx_seq_tb.sv
`timescale 1ns/1ps
module can_blk_tx_seq_tb;

  logic        clk;
  logic        rst_n;
  logic        bit_tick;
  logic        init_mode;
  logic        blk_mode;
  logic        trig_wr;
  logic        trig_wdata;
  logic        rewind_wr;
  logic        gap_wr;
  logic [7:0]  gap_wdata;
  logic [15:0] req_set;
  logic [15:0] req_clr;
  logic [15:0] on_bus;
  logic [15:0] tx_done;
  logic [15:0] tx_req;
  logic        trig;
  logic        rewind_pend;
  logic        rewind_err;
  logic [2:0]  seq_ptr;
  logic        seq_done;
  logic        blk_in_flight;

  int checks = 0;
  int errors = 0;

  can_blk_tx_seq u_dut (
    .clk (clk), .rst_n (rst_n), .bit_tick (bit_tick), .init_mode (init_mode),
    .blk_mode (blk_mode), .trig_wr (trig_wr), .trig_wdata (trig_wdata),
    .rewind_wr (rewind_wr), .gap_wr (gap_wr), .gap_wdata (gap_wdata),
    .req_set (req_set), .req_clr (req_clr), .on_bus (on_bus), .tx_done (tx_done),
    .tx_req (tx_req), .trig (trig), .rewind_pend (rewind_pend),
    .rewind_err (rewind_err), .seq_ptr (seq_ptr), .seq_done (seq_done),
    .blk_in_flight (blk_in_flight)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_trig(input logic v);
    trig_wr = 1'b1; trig_wdata = v;
    step(1);
    trig_wr = 1'b0; trig_wdata = 1'b0;
  endtask

  task automatic write_gap(input logic [7:0] v);
    gap_wr = 1'b1; gap_wdata = v;
    step(1);
    gap_wr = 1'b0;
  endtask

  task automatic pulse_done(input int b);
    tx_done[b] = 1'b1;
    step(1);
    tx_done = '0;
  endtask

  task automatic t_reset();
    check(tx_req == 16'h0, "R1 tx_req", tx_req, 0);
    check({trig, rewind_pend, rewind_err, seq_done, blk_in_flight} == 5'b0, "R1 flags",
          {trig, rewind_pend, rewind_err, seq_done, blk_in_flight}, 0);
    check(seq_ptr == 3'd0, "R1 seq_ptr", seq_ptr, 0);
  endtask

  task automatic t_init_trig();
    init_mode = 1'b1;
    write_trig(1'b1);
    check(trig == 1'b0, "R8 trig in init", trig, 0);
    step(2);
    check(tx_req == 16'h0, "R8 no request", tx_req, 0);
    init_mode = 1'b0;
  endtask

  task automatic t_sw_low();
    req_set[3] = 1'b1; step(1); req_set = '0;
    check(tx_req[3] == 1'b0, "R9 set ignored in block mode", tx_req[3], 0);
    blk_mode = 1'b0;
    req_set[3] = 1'b1; step(1); req_set = '0;
    check(tx_req[3] == 1'b1, "R9 set outside block mode", tx_req[3], 1);
    req_clr[3] = 1'b1; step(1); req_clr = '0;
    check(tx_req[3] == 1'b0, "R9 clear outside block mode", tx_req[3], 0);
    blk_mode = 1'b1;
  endtask

  task automatic t_hi_pass();
    req_set[10] = 1'b1; step(1); req_set = '0;
    check(tx_req == 16'h0400, "R10 set bit 10", tx_req, 16'h0400);
    pulse_done(10);
    check(tx_req == 16'h0, "R10 done clears bit 10", tx_req, 0);
    req_set[12] = 1'b1; step(1); req_set = '0;
    req_clr[12] = 1'b1; step(1); req_clr = '0;
    check(tx_req == 16'h0, "R10 clear bit 12", tx_req, 0);
  endtask

  task automatic t_run_nogap();
    write_gap(8'd0);
    write_trig(1'b1);
    step(1);
    for (int i = 0; i < 8; i++) begin
      check(tx_req[7:0] == 8'(1 << i), "R2 ordered request", tx_req[7:0], 1 << i);
      pulse_done(i);
      if (i < 7) begin
        check(tx_req[7:0] == 8'h0, "R4 not before one cycle", tx_req[7:0], 0);
        step(1);
      end
    end
    check(seq_done == 1'b1, "R5 done pulse", seq_done, 1);
    check(trig == 1'b0, "R5 trigger cleared", trig, 0);
    check(seq_ptr == 3'd0, "R5 pointer parked", seq_ptr, 0);
    step(1);
    check(seq_done == 1'b0, "R5 pulse one cycle", seq_done, 0);
    check(tx_req == 16'h0, "R5 no further request", tx_req, 0);
  endtask

  task automatic t_gap_abort();
    write_gap(8'd3);
    write_trig(1'b1);
    step(1);
    check(tx_req[7:0] == 8'h01, "R2 first request", tx_req[7:0], 1);
    pulse_done(0);
    step(3);
    check(tx_req[7:0] == 8'h00, "R3 gap not elapsed", tx_req[7:0], 0);
    step(1);
    check(tx_req[7:0] == 8'h02, "R3 request after gap", tx_req[7:0], 2);
    bit_tick = 1'b0;
    pulse_done(1);
    step(6);
    check(tx_req[7:0] == 8'h00, "R3 held without tick", tx_req[7:0], 0);
    bit_tick = 1'b1;
    step(3);
    check(tx_req[7:0] == 8'h00, "R3 ticking", tx_req[7:0], 0);
    step(1);
    check(tx_req[7:0] == 8'h04, "R3 request after ticks", tx_req[7:0], 4);
    // abort of buffer 2 while it is not on the bus
    write_trig(1'b0);
    check(blk_in_flight == 1'b1, "R11 still waiting", blk_in_flight, 1);
    req_clr[2] = 1'b1; step(1); req_clr = '0;
    check(tx_req[2] == 1'b0, "R11 request dropped", tx_req[2], 0);
    step(1);
    check(blk_in_flight == 1'b0, "R11 in-flight cleared", blk_in_flight, 0);
    check(seq_ptr == 3'd2, "R11 pointer kept", seq_ptr, 2);
    write_gap(8'd0);
    write_trig(1'b1);
    step(1);
    check(tx_req[7:0] == 8'h04, "R12 resume at pending buffer", tx_req[7:0], 4);
    // abort refused while on the bus
    on_bus[2] = 1'b1;
    write_trig(1'b0);
    req_clr[2] = 1'b1; step(1); req_clr = '0;
    check(tx_req[2] == 1'b1, "R11 clear refused on bus", tx_req[2], 1);
    on_bus = '0;
    pulse_done(2);
    check(tx_req[2] == 1'b0, "R11 done clears", tx_req[2], 0);
    step(1);
    check(blk_in_flight == 1'b0, "R11 idle after done", blk_in_flight, 0);
    check(seq_ptr == 3'd3, "R11 pointer advanced", seq_ptr, 3);
  endtask

  task automatic t_rewind();
    rewind_wr = 1'b1; step(1); rewind_wr = 1'b0;
    check(rewind_pend == 1'b1, "R6 rewind pending", rewind_pend, 1);
    step(1);
    check(rewind_pend == 1'b0, "R6 self-cleared", rewind_pend, 0);
    check(seq_ptr == 3'd0, "R6 pointer rewound", seq_ptr, 0);
    write_trig(1'b1);
    rewind_wr = 1'b1; step(1); rewind_wr = 1'b0;
    check(rewind_err == 1'b1, "R7 error flagged", rewind_err, 1);
    check(rewind_pend == 1'b0, "R7 rewind ignored", rewind_pend, 0);
    check(tx_req[7:0] == 8'h01, "R7 run unaffected", tx_req[7:0], 1);
    write_trig(1'b0);
    req_clr[0] = 1'b1; step(1); req_clr = '0;
    step(1);
  endtask

  initial begin
    rst_n = 1'b0; bit_tick = 1'b1; init_mode = 1'b0; blk_mode = 1'b1;
    trig_wr = 1'b0; trig_wdata = 1'b0; rewind_wr = 1'b0; gap_wr = 1'b0;
    gap_wdata = '0; req_set = '0; req_clr = '0; on_bus = '0; tx_done = '0;
    step(3);
    rst_n = 1'b1;
    step(3);
    t_reset();
    t_init_trig();
    t_sw_low();
    t_hi_pass();
    t_run_nogap();
    t_gap_abort();
    t_rewind();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule